// File: doc/BRIEF.md
# Segmented DAC Thermometer Front-End

This block is the digital front end of a 12-bit segmented current-steering converter. Each input word is split into two parts. The eight upper bits become a thermometer code over 255 equally weighted unary cells. The four lower bits pass through unchanged and drive binary-weighted cells.

The unary decode is built as a matrix of 8 rows by 32 columns. A 3-bit field selects the row and a 5-bit field selects the column. Each column slice decides whether each of its cells is on from three signals:
- its own column-select line,
- the column-select line of the next column,
- a row thermometer shared by all columns.

A compile-time option can reorder the unary cells. When it is enabled, consecutive codes switch cells that sit far apart in the matrix.

Both paths have the same two register stages:
1. An input stage samples on the falling clock edge.
2. A switch stage updates every cell control together on the following rising edge.

Every control leaves the block as a complementary pair. One side of each pair steers the cell to the positive output and the other side to the negative output, so exactly one side is active at any time.

Top module: `dac_seg_frontend`

## Requirements
- R1: After a code has passed through both stages, the number of asserted bits in `unary_p` equals `din[11:4]`, read as an unsigned value from 0 to 255.
- R2: With reordering disabled, bit k of `unary_p` corresponds to column k/8 and row k%8, and it is set exactly when k < `din[11:4]`. The column is `din[11:7]` and the row is `din[6:4]`.
- R3: Bit 255 of `unary_p` (row 7, column 31) is never set.
- R4: `bin_p` equals `din[3:0]`, with bit 0 as the least significant binary cell.
- R5: Outside reset, `unary_n` is the bitwise inverse of `unary_p`, and `bin_n` is the bitwise inverse of `bin_p`.
- R6: `din` is sampled on the falling edge of `clk`. The outputs take the sampled value on the next rising edge and do not change at the falling edge.
- R7: The unary outputs and the binary outputs change on the same rising edge.
- R8: While `rst_n` is low, all registers are cleared at once, without waiting for a clock edge: `unary_p` and `bin_p` are all zero, and `unary_n` and `bin_n` are all ones.
- R9: With reordering enabled, thermometer index i (for i < 255) drives `unary_p` bit (i*PERM_STRIDE) mod 255, and bit 255 stays unused. The on-count of R1 is unchanged.
- R10: When the unary code rises by one between two consecutive samples, exactly one more cell is on and every cell that was on stays on. This holds with and without reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; input stage on falling edge, switch stage on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronous to `clk` |
| din | input | 12 | Input code: bits 11:4 unary part, bits 3:0 binary part |
| unary_p | output | 256 | Positive-side controls of the unary cells (bit 255 unused) |
| unary_n | output | 256 | Negative-side controls of the unary cells |
| bin_p | output | 4 | Positive-side controls of the binary cells |
| bin_n | output | 4 | Negative-side controls of the binary cells |

## Verification
The bench builds two copies of the block with the default widths (3 row bits, 5 column bits, 4 binary bits) and the same input word. The first copy has reordering off, so the exact cell vector can be compared against the plain thermometer for all 4096 codes. The second copy has reordering on with stride 128, which exercises the scattered placement: each step between codes lands on the opposite half of the matrix, while the count and superset rules are still checked. The default size makes an exhaustive sweep cheap. It also reaches both ends of every column slice and the unused last cell.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  // Physical cell for a logical thermometer index. With reordering on,
  // indices below cells-1 are scattered by a stride modulo cells-1, which
  // is a bijection when the stride is coprime with cells-1.
  function automatic int unsigned perm_pos(input int unsigned idx,
                                           input int unsigned cells,
                                           input int unsigned stride,
                                           input bit          en);
    if (!en || idx >= cells - 1) return idx;
    return (idx * stride) % (cells - 1);
  endfunction

endpackage

// File: rtl/dac_fe_sel_decode.sv
module dac_fe_sel_decode #(
  parameter  int ROW_BITS = 3,
  parameter  int COL_BITS = 5,
  localparam int ROWS     = 1 << ROW_BITS,
  localparam int COLS     = 1 << COL_BITS
) (
  input  logic [ROW_BITS-1:0] row_idx,
  input  logic [COL_BITS-1:0] col_idx,
  output logic [ROWS-1:0]     row_th,
  output logic [COLS:0]       col_ge
);

  // Row thermometer: row j is lit in the partial column when row_idx > j.
  always_comb begin
    for (int j = 0; j < ROWS; j++) begin
      row_th[j] = (int'(row_idx) > j);
    end
  end

  // Column select line i is high when col_idx >= i; the extra top line
  // is always low because col_idx never reaches COLS.
  always_comb begin
    for (int i = 0; i <= COLS; i++) begin
      col_ge[i] = (int'(col_idx) >= i);
    end
  end

endmodule

// File: rtl/dac_fe_col_slice.sv
module dac_fe_col_slice #(
  parameter int ROWS = 8
) (
  input  logic            col_here,
  input  logic            col_next,
  input  logic [ROWS-1:0] row_th,
  output logic [ROWS-1:0] cell_on
);

  // Column fully on when the next select line is high; partially on,
  // by the row thermometer, when only its own select line is high.
  always_comb begin
    cell_on = {ROWS{col_next}} | ({ROWS{col_here}} & row_th);
  end

endmodule

// File: rtl/dac_fe_switch_stage.sv
module dac_fe_switch_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] out_p,
  output logic [W-1:0] out_n
);

  logic [W-1:0] q;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  assign out_p = q;
  assign out_n = ~q;

endmodule

// File: rtl/dac_seg_frontend.sv
module dac_seg_frontend #(
  parameter  int ROW_BITS    = 3,
  parameter  int COL_BITS    = 5,
  parameter  int BIN_BITS    = 4,
  parameter  bit PERMUTE     = 1'b0,
  parameter  int PERM_STRIDE = 128,
  localparam int UNARY_BITS  = ROW_BITS + COL_BITS,
  localparam int DW          = UNARY_BITS + BIN_BITS,
  localparam int ROWS        = 1 << ROW_BITS,
  localparam int COLS        = 1 << COL_BITS,
  localparam int CELLS       = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    din,
  output logic [CELLS-1:0] unary_p,
  output logic [CELLS-1:0] unary_n,
  output logic [BIN_BITS-1:0] bin_p,
  output logic [BIN_BITS-1:0] bin_n
);

  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [ROWS-1:0]     row_th;
  logic [COLS:0]       col_ge;
  logic [CELLS-1:0]    therm_log;
  logic [CELLS-1:0]    therm_phys;

  logic [CELLS-1:0]    unary_s1, unary_s1_nxt;
  logic [BIN_BITS-1:0] bin_s1, bin_s1_nxt;

  assign row_idx = din[BIN_BITS +: ROW_BITS];
  assign col_idx = din[BIN_BITS + ROW_BITS +: COL_BITS];

  dac_fe_sel_decode #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_sel (
    .row_idx (row_idx),
    .col_idx (col_idx),
    .row_th  (row_th),
    .col_ge  (col_ge)
  );

  // One slice per column; logical index = column*ROWS + row.
  for (genvar c = 0; c < COLS; c++) begin : g_col
    dac_fe_col_slice #(
      .ROWS (ROWS)
    ) u_slice (
      .col_here (col_ge[c]),
      .col_next (col_ge[c+1]),
      .row_th   (row_th),
      .cell_on  (therm_log[c*ROWS +: ROWS])
    );
  end

  // Fixed placement map, identity when PERMUTE is off.
  for (genvar i = 0; i < CELLS; i++) begin : g_place
    localparam int unsigned PHYS =
      dac_fe_pkg::perm_pos(i, CELLS, PERM_STRIDE, PERMUTE);
    assign therm_phys[PHYS] = therm_log[i];
  end

  // Input stage on the falling edge.
  always_comb begin
    unary_s1_nxt = therm_phys;
    bin_s1_nxt   = din[BIN_BITS-1:0];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unary_s1 <= '0;
      bin_s1   <= '0;
    end else begin
      unary_s1 <= unary_s1_nxt;
      bin_s1   <= bin_s1_nxt;
    end
  end

  // Switch stage on the rising edge, same for both segments.
  dac_fe_switch_stage #(
    .W (CELLS)
  ) u_sw_unary (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (unary_s1),
    .out_p (unary_p),
    .out_n (unary_n)
  );

  dac_fe_switch_stage #(
    .W (BIN_BITS)
  ) u_sw_bin (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bin_s1),
    .out_p (bin_p),
    .out_n (bin_n)
  );

endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk #(
  parameter  int UNARY_BITS = 8,
  parameter  int BIN_BITS   = 4,
  parameter  int CELLS      = 256,
  localparam int DW         = UNARY_BITS + BIN_BITS
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DW-1:0]       din,
  input logic [CELLS-1:0]    unary_p,
  input logic [CELLS-1:0]    unary_n,
  input logic [BIN_BITS-1:0] bin_p,
  input logic [BIN_BITS-1:0] bin_n
);

  logic [DW-1:0] din_seen;
  logic [1:0]    primed;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) din_seen <= '0;
    else        din_seen <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              primed <= '0;
    else if (primed != 2'd3) primed <= primed + 2'd1;
  end

  // R1
  unary_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed != 2'd0) |->
      $countones(unary_p) == int'($past(din_seen[DW-1:BIN_BITS])));

  // R4 R7
  bin_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed != 2'd0) |-> bin_p == $past(din_seen[BIN_BITS-1:0]));

  // R3
  last_cell_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unary_p[CELLS-1]);

  // R5
  pair_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unary_n == ~unary_p) && (bin_n == ~bin_p));

  // R8
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |-> (unary_p == '0) && (bin_p == '0) && (unary_n == '1) && (bin_n == '1));

  // R10
  step_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed == 2'd3 &&
     $past(din_seen[DW-1:BIN_BITS], 1) == $past(din_seen[DW-1:BIN_BITS], 2) + 1) |->
      ((unary_p & $past(unary_p)) == $past(unary_p)) &&
      ($countones(unary_p) == $countones($past(unary_p)) + 1));

endmodule

bind dac_seg_frontend dac_fe_chk #(
  .UNARY_BITS (UNARY_BITS),
  .BIN_BITS   (BIN_BITS),
  .CELLS      (CELLS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .din     (din),
  .unary_p (unary_p),
  .unary_n (unary_n),
  .bin_p   (bin_p),
  .bin_n   (bin_n)
);

// File: tb/dac_seg_frontend_tb.sv
module dac_seg_frontend_tb;

  localparam int CELLS  = 256;
  localparam int STRIDE = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [11:0]       din;
  logic [CELLS-1:0]  p0, n0, p1, n1;
  logic [3:0]        bp0, bn0, bp1, bn1;

  int n_chk  = 0;
  int n_fail = 0;

  // {din, expected on-count, expected binary}
  localparam logic [24:0] VEC [12] = '{
    {12'h000, 9'd0,   4'h0}, {12'h00F, 9'd0,   4'hF},
    {12'h010, 9'd1,   4'h0}, {12'h07F, 9'd7,   4'hF},
    {12'h080, 9'd8,   4'h0}, {12'h0FF, 9'd15,  4'hF},
    {12'h7F0, 9'd127, 4'h0}, {12'h800, 9'd128, 4'h0},
    {12'hF7A, 9'd247, 4'hA}, {12'hFF0, 9'd255, 4'h0},
    {12'hFFF, 9'd255, 4'hF}, {12'h5A5, 9'd90,  4'h5}
  };

  dac_seg_frontend #(.PERMUTE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .unary_p(p0), .unary_n(n0), .bin_p(bp0), .bin_n(bn0));

  dac_seg_frontend #(.PERMUTE(1'b1), .PERM_STRIDE(STRIDE)) u_dut_perm (
    .clk(clk), .rst_n(rst_n), .din(din),
    .unary_p(p1), .unary_n(n1), .bin_p(bp1), .bin_n(bn1));

  function automatic logic [CELLS-1:0] exp_therm(input int code);
    logic [CELLS-1:0] v = '0;
    for (int k = 0; k < code; k++) v[k] = 1'b1;
    return v;
  endfunction

  function automatic logic [CELLS-1:0] exp_perm(input int code);
    logic [CELLS-1:0] v = '0;
    for (int i = 0; i < code; i++) v[(i * STRIDE) % (CELLS - 1)] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] v);
    din = v;
    @(posedge clk);
    #1;
  endtask

  task automatic check_code(input logic [11:0] v);
    int code = int'(v[11:4]);
    check($countones(p0) == code, "R1 count", 256'($countones(p0)), 256'(code));
    check(p0 == exp_therm(code), "R2 thermometer", p0, exp_therm(code));
    check(!p0[CELLS-1] && !p1[CELLS-1], "R3 last cell", {p0[CELLS-1], p1[CELLS-1]}, 256'(0));
    check(bp0 == v[3:0] && bp1 == v[3:0], "R4 binary", 256'({bp0, bp1}), 256'({v[3:0], v[3:0]}));
    check(n0 == ~p0 && n1 == ~p1 && bn0 == ~bp0 && bn1 == ~bp1, "R5 pairs", n0, ~p0);
    check(p1 == exp_perm(code) && $countones(p1) == code, "R9 reorder", p1, exp_perm(code));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CELLS-1:0] prev0, prev1;
    logic [11:0] r;
    rst_n = 1'b0;
    din   = 12'hFFF;
    repeat (2) @(posedge clk);
    #1;
    // R8 reset state
    check(p0 == '0 && p1 == '0, "R8 reset p", p0 | p1, '0);
    check(n0 == '1 && bn0 == 4'hF && bp0 == 4'h0, "R8 reset n", n0, '1);
    rst_n = 1'b1;

    // Table walk
    foreach (VEC[i]) begin
      apply(VEC[i][24:13]);
      check($countones(p0) == int'(VEC[i][12:4]), "R1 table count",
            256'($countones(p0)), 256'(VEC[i][12:4]));
      check(bp0 == VEC[i][3:0], "R4 table binary", 256'(bp0), 256'(VEC[i][3:0]));
    end

    // Exhaustive ascending sweep with step checks
    apply(12'h000);
    prev0 = p0;
    prev1 = p1;
    for (int v = 0; v < 4096; v++) begin
      apply(12'(v));
      check_code(12'(v));
      if (v > 0 && v[3:0] == 4'h0) begin
        check((p0 & prev0) == prev0 && $countones(p0) == $countones(prev0) + 1,
              "R10 step plain", p0, prev0);
        check((p1 & prev1) == prev1 && $countones(p1) == $countones(prev1) + 1,
              "R10 step reorder", p1, prev1);
      end
      prev0 = p0;
      prev1 = p1;
    end

    // Random jumps
    for (int k = 0; k < 300; k++) begin
      r = 12'($urandom);
      apply(r);
      check_code(r);
    end

    // R6 R7 latency: nothing moves at the falling edge, all at the rising edge
    apply(12'h123);
    din = 12'hE9C;
    #5;
    check(p0 == exp_therm(8'h12), "R6 held at falling edge", p0, exp_therm(8'h12));
    check(bp0 == 4'h3, "R7 binary held", 256'(bp0), 256'(4'h3));
    @(posedge clk);
    #1;
    check(p0 == exp_therm(8'hE9), "R6 updated at rising edge", p0, exp_therm(8'hE9));
    check(bp0 == 4'hC, "R7 binary with unary", 256'(bp0), 256'(4'hC));

    // R8 asynchronous clear mid-cycle
    #2;
    rst_n = 1'b0;
    #1;
    check(p0 == '0 && p1 == '0 && bp0 == 4'h0, "R8 async clear", p0 | p1, '0);
    check(n0 == '1 && bn1 == 4'hF, "R8 async negative side", n0, '1);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    apply(12'h7C3);
    check_code(12'h7C3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule